// File: doc/BRIEF.md
# Cache-Line Store Backup Buffer

This block keeps an ordered record of stores that allocate a cache line. It holds them so that a later line-invalidate can push the data to memory before the line is thrown away. A record request carries an address, a data word and a cacheable flag. Only cacheable requests are kept, and they are appended at the tail, so the buffer always holds entries in arrival order. A discard-all command empties the buffer and writes nothing.

A line-invalidate command names an address. The block then scans its entries from oldest to newest. Every entry in the same 32-byte line as the command address is offered to memory over a valid/ready write port, using its stored address and data, and is then removed. Entries outside that line are moved toward the head in their original order, so no gaps remain and the occupancy count equals the number of entries left.

During a scan the block shows busy and withdraws its command-ready signal. Any record, discard or invalidate presented in that time is ignored. A cacheable record that arrives while the buffer is full is dropped, and the block raises an overflow pulse.

Top module: `line_backup_buf`

## Requirements
- R1: After reset the buffer is empty: count is 0, cmd_ready is 1, and busy, mem_valid and overflow are 0.
- R2: While cmd_ready is 1, a record with rec_cacheable=1 is appended at the tail and count rises by one on the next cycle. A record with rec_cacheable=0 leaves count unchanged and is never written to memory.
- R3: While cmd_ready is 1, discard sets count to 0 on the next cycle and produces no memory write. It takes precedence over a record or an invalidate presented in the same cycle, and both of those are then ignored.
- R4: An accepted invalidate writes every entry whose address matches inv_addr with bits 4:0 ignored. Each such entry goes out on mem_addr/mem_data with its stored values, one entry per cycle in which mem_valid and mem_ready are both high, oldest first.
- R5: Entries outside the invalidated line stay in the buffer in their original relative order. When the scan ends, count equals the number of entries that remain.
- R6: From the cycle after an invalidate is accepted until the scan ends, busy is 1 and cmd_ready is 0. Records, discards and invalidates presented in that time are ignored.
- R7: While mem_valid is 1 and mem_ready is 0, mem_valid stays 1 and mem_addr and mem_data stay unchanged on the next cycle.
- R8: A cacheable record presented while count equals DEPTH is dropped: count stays at DEPTH, and overflow is 1 for exactly the following cycle.
- R9: A record and an invalidate presented together while cmd_ready is 1 append the record first. The scan then includes the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Record request strobe |
| rec_cacheable | input | 1 | Record address is cacheable |
| rec_addr | input | AW | Record address |
| rec_data | input | DW | Record data word |
| discard | input | 1 | Drop all entries |
| inv_valid | input | 1 | Line-invalidate strobe |
| inv_addr | input | AW | Address naming the line to invalidate |
| cmd_ready | output | 1 | Commands are accepted this cycle |
| busy | output | 1 | Invalidate scan in progress |
| count | output | $clog2(DEPTH+1) | Number of held entries |
| overflow | output | 1 | Pulse: a record was dropped because the buffer was full |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Write address |
| mem_data | output | DW | Write data |

## Verification
Appending and starting a line scan can happen in the same cycle. The bench provokes this by presenting a cacheable record and an invalidate for the same line together. It then expects the new word to come out on the memory port and the count to return to zero. It also presents a record, a discard and an invalidate together, and expects an empty buffer with no write. This confirms that discard wins over the other two.

// File: rtl/lbb_pkg.sv
package lbb_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_SCAN = 1'b1
    } scan_state_e;
endpackage

// File: rtl/lbb_line_cmp.sv
module lbb_line_cmp #(
    parameter int AW        = 32,
    parameter int LINE_BITS = 5
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic          hit
);
    // Offset bits inside a line take no part in the comparison.
    assign hit = (a[AW-1:LINE_BITS] == b[AW-1:LINE_BITS]);
endmodule

// File: rtl/lbb_entry_store.sv
module lbb_entry_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             trim_en,
    input  logic [CW-1:0]    trim_cnt,
    input  logic [IW-1:0]    rd_idx,
    output logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [DEPTH-1:0] valid_vec
);
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] valid_d;

    // Next valid bit per slot: set by a write, cleared above the trim point.
    for (genvar g = 0; g < DEPTH; g++) begin : g_valid
        assign valid_d[g] = (trim_en && (CW'(g) >= trim_cnt)) ? 1'b0 :
                            ((wr_en && (wr_idx == IW'(g))) ? 1'b1 : valid_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && (wr_idx == IW'(i))) begin
                    addr_q[i] <= wr_addr;
                    data_q[i] <= wr_data;
                end
            end
        end
    end

    assign rd_addr   = addr_q[rd_idx];
    assign rd_data   = data_q[rd_idx];
    assign valid_vec = valid_q;
endmodule

// File: rtl/line_backup_buf.sv
module line_backup_buf #(
    parameter int DEPTH     = 8,
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int LINE_BITS = 5,
    localparam int IW       = $clog2(DEPTH),
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_valid,
    input  logic          rec_cacheable,
    input  logic [AW-1:0] rec_addr,
    input  logic [DW-1:0] rec_data,
    input  logic          discard,
    input  logic          inv_valid,
    input  logic [AW-1:0] inv_addr,
    output logic          cmd_ready,
    output logic          busy,
    output logic [CW-1:0] count,
    output logic          overflow,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);
    import lbb_pkg::*;

    typedef struct packed {
        scan_state_e   st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] rd;
        logic [CW-1:0] wr;
        logic [AW-1:0] line;
        logic          ovf;
    } ctl_t;

    ctl_t q, d;

    logic             st_wr_en;
    logic [IW-1:0]    st_wr_idx;
    logic [AW-1:0]    st_wr_addr;
    logic [DW-1:0]    st_wr_data;
    logic             st_trim_en;
    logic [CW-1:0]    st_trim_cnt;
    logic [AW-1:0]    rd_addr;
    logic [DW-1:0]    rd_data;
    logic [DEPTH-1:0] valid_vec;
    logic             line_hit;

    lbb_entry_store #(
        .DEPTH(DEPTH),
        .AW   (AW),
        .DW   (DW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_wr_en),
        .wr_idx   (st_wr_idx),
        .wr_addr  (st_wr_addr),
        .wr_data  (st_wr_data),
        .trim_en  (st_trim_en),
        .trim_cnt (st_trim_cnt),
        .rd_idx   (q.rd[IW-1:0]),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .valid_vec(valid_vec)
    );

    lbb_line_cmp #(
        .AW       (AW),
        .LINE_BITS(LINE_BITS)
    ) u_cmp (
        .a  (rd_addr),
        .b  (q.line),
        .hit(line_hit)
    );

    always_comb begin
        d           = q;
        d.ovf       = 1'b0;
        st_wr_en    = 1'b0;
        st_wr_idx   = '0;
        st_wr_addr  = rec_addr;
        st_wr_data  = rec_data;
        st_trim_en  = 1'b0;
        st_trim_cnt = '0;
        mem_valid   = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (discard) begin
                    d.cnt      = '0;
                    st_trim_en = 1'b1;
                end else begin
                    if (rec_valid && rec_cacheable) begin
                        if (q.cnt == CW'(DEPTH)) begin
                            d.ovf = 1'b1;
                        end else begin
                            st_wr_en  = 1'b1;
                            st_wr_idx = q.cnt[IW-1:0];
                            d.cnt     = q.cnt + 1'b1;
                        end
                    end
                    if (inv_valid) begin
                        d.st   = S_SCAN;
                        d.rd   = '0;
                        d.wr   = '0;
                        d.line = inv_addr;
                    end
                end
            end
            S_SCAN: begin
                if (q.rd == q.cnt) begin
                    d.st        = S_IDLE;
                    d.cnt       = q.wr;
                    st_trim_en  = 1'b1;
                    st_trim_cnt = q.wr;
                end else if (line_hit) begin
                    mem_valid = 1'b1;
                    if (mem_ready) begin
                        d.rd = q.rd + 1'b1;
                    end
                end else begin
                    // Survivor: slide it down to the packing point.
                    st_wr_en   = (q.wr != q.rd);
                    st_wr_idx  = q.wr[IW-1:0];
                    st_wr_addr = rd_addr;
                    st_wr_data = rd_data;
                    d.rd       = q.rd + 1'b1;
                    d.wr       = q.wr + 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, cnt: '0, rd: '0, wr: '0, line: '0, ovf: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st == S_SCAN);
    assign cmd_ready = ~busy;
    assign count     = q.cnt;
    assign overflow  = q.ovf;
    assign mem_addr  = rd_addr;
    assign mem_data  = rd_data;

    // R7
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R3
    discard_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && discard) |=> (count == '0));

    // R8
    ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> ($past(count) == CW'(DEPTH) && count == CW'(DEPTH)));

    // R5
    packed_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (valid_vec == ({DEPTH{1'b1}} >> (CW'(DEPTH) - count))));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: tb/line_backup_buf_test.sv
`timescale 1ns/1ps
module line_backup_buf_test;
    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rec_valid = 1'b0, rec_cacheable = 1'b0;
    logic [AW-1:0] rec_addr = '0;
    logic [DW-1:0] rec_data = '0;
    logic          discard = 1'b0, inv_valid = 1'b0;
    logic [AW-1:0] inv_addr = '0;
    logic          cmd_ready, busy, overflow, mem_valid;
    logic          mem_ready = 1'b1;
    logic [CW-1:0] count;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    always #5 clk = ~clk;

    line_backup_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_cacheable(rec_cacheable),
        .rec_addr(rec_addr), .rec_data(rec_data), .discard(discard),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .cmd_ready(cmd_ready), .busy(busy),
        .count(count), .overflow(overflow), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [AW-1:0] cap_addr [64];
    logic [DW-1:0] cap_data [64];
    int cap_n = 0;
    int rdy_mode = 0;   // 0 always ready, 1 alternating, 2 held low
    logic          waiting = 1'b0;
    logic [AW-1:0] wait_addr = '0;
    logic [DW-1:0] wait_data = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0:       mem_ready = 1'b1;
            1:       mem_ready = ~mem_ready;
            default: mem_ready = 1'b0;
        endcase
    end

    // Capture handshakes mid-cycle; R7 hold check on stalled requests.
    always @(negedge clk) begin
        if (rst_n) begin
            if (waiting) begin
                check(mem_valid && mem_addr == wait_addr && mem_data == wait_data,
                      "R7 hold", mem_addr, wait_addr);
            end
            waiting   = mem_valid && !mem_ready;
            wait_addr = mem_addr;
            wait_data = mem_data;
            if (mem_valid && mem_ready && cap_n < 64) begin
                cap_addr[cap_n] = mem_addr;
                cap_data[cap_n] = mem_data;
                cap_n++;
            end
        end
    end

    task automatic cmd(input bit rv, input bit rc, input logic [31:0] ra, input logic [31:0] rd,
                       input bit dis, input bit iv, input logic [31:0] ia);
        @(posedge clk); #1;
        rec_valid = rv; rec_cacheable = rc; rec_addr = ra; rec_data = rd;
        discard = dis; inv_valid = iv; inv_addr = ia;
        @(posedge clk); #1;
        rec_valid = 0; rec_cacheable = 0; discard = 0; inv_valid = 0;
    endtask

    task automatic rec(input logic [31:0] a, input logic [31:0] dd);
        cmd(1, 1, a, dd, 0, 0, 0);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic inv(input logic [31:0] a);
        cmd(0, 0, 0, 0, 0, 1, a);
        wait_idle();
    endtask

    typedef struct packed {
        logic [1:0]  op;      // 0 record, 1 discard, 2 invalidate
        logic        cach;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  exp_cnt;
        logic [3:0]  exp_wr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 32'h1000, 32'hA1, 4'd1, 4'd0},
        '{2'd0, 1'b0, 32'h2000, 32'hA9, 4'd1, 4'd0},
        '{2'd0, 1'b1, 32'h1004, 32'hA2, 4'd2, 4'd0},
        '{2'd0, 1'b1, 32'h3000, 32'hA3, 4'd3, 4'd0},
        '{2'd1, 1'b0, 32'h0,    32'h0,  4'd0, 4'd0},
        '{2'd0, 1'b1, 32'h1008, 32'hA4, 4'd1, 4'd0},
        '{2'd0, 1'b1, 32'h4000, 32'hA5, 4'd2, 4'd0},
        '{2'd2, 1'b0, 32'h101F, 32'h0,  4'd1, 4'd1},
        '{2'd1, 1'b0, 32'h0,    32'h0,  4'd0, 4'd0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R6: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(count == 0, "R1 count", count, 0);
        check(cmd_ready && !busy, "R1 ready/busy", {busy, cmd_ready}, 1);
        check(!mem_valid && !overflow, "R1 mem_valid/overflow", {mem_valid, overflow}, 0);

        // Table walk: R2 append/ignore, R3 discard, R5 remaining count
        for (int k = 0; k < NV; k++) begin
            base = cap_n;
            case (VEC[k].op)
                2'd0: cmd(1, VEC[k].cach, VEC[k].addr, VEC[k].data, 0, 0, 0);
                2'd1: cmd(0, 0, 0, 0, 1, 0, 0);
                default: inv(VEC[k].addr);
            endcase
            @(negedge clk);
            check(count == CW'(VEC[k].exp_cnt),
                  (VEC[k].op == 0) ? "R2 table count" : (VEC[k].op == 1) ? "R3 table count" : "R5 table count",
                  count, VEC[k].exp_cnt);
            check(cap_n - base == int'(VEC[k].exp_wr),
                  (VEC[k].op == 2) ? "R4 table writes" : "R3 table writes", cap_n - base, VEC[k].exp_wr);
        end
        check(cap_addr[0] == 32'h1008 && cap_data[0] == 32'hA4, "R4 table data", cap_data[0], 32'hA4);

        // R4/R5: ordered replay with stalls, compaction keeps order
        rdy_mode = 1;
        rec(32'h100, 32'hD1); rec(32'h200, 32'hD2); rec(32'h110, 32'hD3);
        rec(32'h300, 32'hD4); rec(32'h11C, 32'hD5);
        base = cap_n;
        inv(32'h105);
        @(negedge clk);
        check(cap_n - base == 3, "R4 match writes", cap_n - base, 3);
        check(cap_data[base] == 32'hD1 && cap_addr[base] == 32'h100, "R4 first oldest", cap_data[base], 32'hD1);
        check(cap_data[base+1] == 32'hD3 && cap_addr[base+1] == 32'h110, "R4 second", cap_data[base+1], 32'hD3);
        check(cap_data[base+2] == 32'hD5 && cap_addr[base+2] == 32'h11C, "R4 third", cap_data[base+2], 32'hD5);
        check(count == 2, "R5 remaining", count, 2);
        rec(32'h204, 32'hD6);
        base = cap_n;
        inv(32'h21F);
        @(negedge clk);
        check(cap_n - base == 2 && cap_data[base] == 32'hD2 && cap_data[base+1] == 32'hD6,
              "R5 order kept", cap_data[base], 32'hD2);
        check(count == 1, "R5 count after second scan", count, 1);
        base = cap_n;
        inv(32'h300);
        @(negedge clk);
        check(cap_n - base == 1 && cap_data[base] == 32'hD4, "R5 survivor data", cap_data[base], 32'hD4);
        check(count == 0, "R5 empty", count, 0);

        // R6: commands during a stalled scan are ignored
        rdy_mode = 0;
        rec(32'h500, 32'hE7); rec(32'h600, 32'hE8);
        rdy_mode = 2;
        base = cap_n;
        cmd(0, 0, 0, 0, 0, 1, 32'h500);
        check(busy && !cmd_ready, "R6 busy during scan", {busy, cmd_ready}, 2);
        cmd(1, 1, 32'h700, 32'hE9, 1, 1, 32'h600);
        @(negedge clk);
        check(mem_valid && mem_addr == 32'h500, "R6 scan stalled on match", mem_addr, 32'h500);
        rdy_mode = 0;
        wait_idle();
        @(negedge clk);
        check(count == 1, "R6 record/discard ignored", count, 1);
        check(cap_n - base == 1 && cap_data[base] == 32'hE7, "R6 single write", cap_data[base], 32'hE7);
        base = cap_n;
        inv(32'h600);
        @(negedge clk);
        check(cap_n - base == 1 && cap_data[base] == 32'hE8 && count == 0, "R6 entry kept", cap_data[base], 32'hE8);

        // R9: record and invalidate in one cycle
        base = cap_n;
        cmd(1, 1, 32'h800, 32'hF9, 0, 1, 32'h800);
        wait_idle();
        @(negedge clk);
        check(cap_n - base == 1 && cap_data[base] == 32'hF9, "R9 new entry replayed", cap_data[base], 32'hF9);
        check(count == 0, "R9 count", count, 0);

        // R3 precedence: discard beats record and invalidate
        rec(32'h900, 32'hC1);
        base = cap_n;
        cmd(1, 1, 32'h904, 32'hC2, 1, 1, 32'h900);
        @(negedge clk);
        check(count == 0 && !busy, "R3 discard precedence", count, 0);
        check(cap_n == base, "R3 no write", cap_n - base, 0);

        // R8: overflow when full
        for (int i = 0; i < DEPTH; i++) rec(32'hB000 + i * 32, 32'h50 + i);
        check(count == CW'(DEPTH), "R8 full count", count, DEPTH);
        rec(32'hB100, 32'h77);
        check(overflow == 1'b1, "R8 overflow pulse", overflow, 1);
        check(count == CW'(DEPTH), "R8 dropped", count, DEPTH);
        @(posedge clk); #1;
        check(overflow == 1'b0, "R8 pulse one cycle", overflow, 0);
        base = cap_n;
        inv(32'hB0E0);
        @(negedge clk);
        check(cap_n - base == 1 && cap_data[base] == 32'h57, "R8 newest kept entry", cap_data[base], 32'h57);
        check(count == CW'(DEPTH - 1), "R8 count after scan", count, DEPTH - 1);
        cmd(0, 0, 0, 0, 1, 0, 0);
        @(negedge clk);
        check(count == 0, "R3 final discard", count, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule